// File: doc/BRIEF.md
# Fixed-OR Macrocell Array with Pin Feedback

This block is an array of output sections built around a fixed OR structure. Each section owns a small set of programmable product terms that feed one OR gate of fixed width. No product term is shared between sections. A separate product term in every section controls the output enable of that section's bidirectional pin. The pin is modelled as three signals: a driven value, an enable and the value seen on the wire.

Every pin's value comes back into the shared AND plane through a feedback path. While a section drives its pin, the feedback carries the section's own result. While it does not drive, the feedback carries the external pin input. One section can therefore compute a first-pass partial sum, and another section can consume it. Functions with more products than a single OR gate can take are built this way, and an undriven pin can serve as an extra input. A section never sees its own feedback.

Term contents are loaded through a synchronous configuration port. The port takes a section address, a term index and the code word for that term. The pin value and the enable are registered, so each evaluation stage costs one clock. A two-stage function built through a helper section settles two clocks after its inputs change.

Top module: `pal_macro_array`

## Requirements
- R1: A synchronous active-high reset clears every stored term to all force-0 codes. One clock after reset, pin_out and pin_oe are 0 for every section.
- R2: AND-plane signal j takes bits [2j+1:2j] of a term word. The signals are ordered as follows: indices 0 to N_IN-1 are ded_in bits, and index N_IN+s is the feedback of section s. Code 2'b01 passes the signal, 2'b10 passes its complement, 2'b11 is don't-care (true) and 2'b00 forces the whole term to 0. A term is the AND of its passed codes.
- R3: On each clock, pin_out[s] loads the OR of section s's four sum terms (term indices 0 to 3), evaluated on the inputs present before that edge.
- R4: On each clock, pin_oe[s] loads section s's enable term (term index 4). An all-don't-care enable term keeps the pin enabled on every cycle.
- R5: The feedback of section s equals pin_out[s] while pin_oe[s] is 1, and equals pin_in[s] while pin_oe[s] is 0.
- R6: The code at a section's own feedback position is ignored in all of that section's terms, and is treated as don't-care.
- R7: When cfg_we is 1, the word cfg_data is stored into term cfg_term of section cfg_sec at the clock edge, and the stored term takes part in the next evaluation. A write with cfg_term above 4 changes nothing.
- R8: A write to one section leaves the outputs of every other section unchanged.
- R9: A six-product function of the dedicated inputs is formed with two sections. A helper section produces four of the products. A second section ORs the helper's feedback with the remaining two products. The result appears two clocks after the inputs are applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Term write strobe |
| cfg_sec | input | SEC_W | Section address of the write |
| cfg_term | input | TIDX_W | Term index: 0 to 3 are sum terms, 4 is the enable term |
| cfg_data | input | 2*(N_IN+N_SEC) | Code word, 2 bits per AND-plane signal |
| ded_in | input | N_IN | Dedicated logic inputs |
| pin_in | input | N_SEC | Value seen on each bidirectional pin |
| pin_out | output | N_SEC | Registered value each section drives |
| pin_oe | output | N_SEC | Registered output enable of each pin |

## Verification
The assertions assume that reset is held for at least one clock before any configuration is written. They also assume that a section with no stored sum or enable term that could be true keeps its pin low and disabled. This lets them tie the quiet state of each pin to the history of valid, non-zero writes, which the checker tracks itself. The stimulus makes every write only after a reset. It clears the configuration with a fresh reset before each scenario, instead of relying on overwrites. It holds the dedicated and pin inputs steady for the two clocks a feedback chain needs before a scenario's result is sampled.

// File: rtl/pal_pkg.sv
package pal_pkg;

  typedef enum logic [1:0] {
    CODE_ZERO = 2'b00,
    CODE_TRUE = 2'b01,
    CODE_COMP = 2'b10,
    CODE_ANY  = 2'b11
  } pal_code_e;

  // Contribution of one AND-plane signal under its 2-bit code.
  function automatic logic lit_pass(input logic [1:0] code, input logic sig);
    case (pal_code_e'(code))
      CODE_TRUE: lit_pass = sig;
      CODE_COMP: lit_pass = ~sig;
      CODE_ANY:  lit_pass = 1'b1;
      default:   lit_pass = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/pal_term_cell.sv
module pal_term_cell #(
  parameter int N_SIG   = 8,
  parameter int OWN_IDX = 4,
  localparam int CODE_W = 2 * N_SIG
) (
  input  logic [N_SIG-1:0]  sig,
  input  logic [CODE_W-1:0] code,
  output logic              hit
);
  import pal_pkg::*;

  always_comb begin
    hit = 1'b1;
    for (int j = 0; j < N_SIG; j++) begin
      // own feedback never enters a section's terms
      if (j != OWN_IDX) hit = hit & lit_pass(code[2*j +: 2], sig[j]);
    end
  end

endmodule

// File: rtl/pal_section.sv
module pal_section #(
  parameter int N_SIG   = 8,
  parameter int N_SUM   = 4,
  parameter int OWN_IDX = 4,
  parameter int TIDX_W  = 3,
  localparam int CODE_W = 2 * N_SIG,
  localparam int N_TERM = N_SUM + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [TIDX_W-1:0] wr_term,
  input  logic [CODE_W-1:0] wr_data,
  input  logic [N_SIG-1:0]  sig,
  output logic              out_q,
  output logic              oe_q
);

  logic [CODE_W-1:0] terms [N_TERM];
  logic [N_TERM-1:0] hits;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int t = 0; t < N_TERM; t++) terms[t] <= '0;
    end else if (wr_en && (int'(wr_term) < N_TERM)) begin
      terms[wr_term] <= wr_data;
    end
  end

  for (genvar t = 0; t < N_TERM; t++) begin : g_term
    pal_term_cell #(
      .N_SIG  (N_SIG),
      .OWN_IDX(OWN_IDX)
    ) cell_i (
      .sig (sig),
      .code(terms[t]),
      .hit (hits[t])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q <= 1'b0;
      oe_q  <= 1'b0;
    end else begin
      out_q <= |hits[N_SUM-1:0];
      oe_q  <= hits[N_SUM];
    end
  end

endmodule

// File: rtl/pal_macro_array.sv
module pal_macro_array #(
  parameter int N_IN  = 4,
  parameter int N_SEC = 4,
  parameter int N_SUM = 4,
  localparam int N_SIG  = N_IN + N_SEC,
  localparam int CODE_W = 2 * N_SIG,
  localparam int SEC_W  = (N_SEC > 1) ? $clog2(N_SEC) : 1,
  localparam int TIDX_W = $clog2(N_SUM + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [SEC_W-1:0]  cfg_sec,
  input  logic [TIDX_W-1:0] cfg_term,
  input  logic [CODE_W-1:0] cfg_data,
  input  logic [N_IN-1:0]   ded_in,
  input  logic [N_SEC-1:0]  pin_in,
  output logic [N_SEC-1:0]  pin_out,
  output logic [N_SEC-1:0]  pin_oe
);

  logic [N_SEC-1:0] fb;
  logic [N_SIG-1:0] plane;

  for (genvar s = 0; s < N_SEC; s++) begin : g_fb
    assign fb[s] = pin_oe[s] ? pin_out[s] : pin_in[s];
  end

  assign plane = {fb, ded_in};

  for (genvar s = 0; s < N_SEC; s++) begin : g_sec
    pal_section #(
      .N_SIG  (N_SIG),
      .N_SUM  (N_SUM),
      .OWN_IDX(N_IN + s),
      .TIDX_W (TIDX_W)
    ) sec_i (
      .clk    (clk),
      .rst    (rst),
      .wr_en  (cfg_we && (cfg_sec == SEC_W'(s))),
      .wr_term(cfg_term),
      .wr_data(cfg_data),
      .sig    (plane),
      .out_q  (pin_out[s]),
      .oe_q   (pin_oe[s])
    );
  end

endmodule

// File: rtl/pal_macro_array_chk.sv
module pal_macro_array_chk #(
  parameter int N_SEC  = 4,
  parameter int N_SUM  = 4,
  parameter int SEC_W  = 2,
  parameter int TIDX_W = 3,
  parameter int CODE_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_we,
  input logic [SEC_W-1:0]  cfg_sec,
  input logic [TIDX_W-1:0] cfg_term,
  input logic [CODE_W-1:0] cfg_data,
  input logic [N_SEC-1:0]  pin_out,
  input logic [N_SEC-1:0]  pin_oe
);

  logic [N_SEC-1:0] sum_seen;
  logic [N_SEC-1:0] en_seen;
  logic             any_seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_seen <= '0;
      en_seen  <= '0;
      any_seen <= 1'b0;
    end else if (cfg_we && (cfg_data != '0)) begin
      for (int s = 0; s < N_SEC; s++) begin
        if (cfg_sec == SEC_W'(s)) begin
          if (int'(cfg_term) < N_SUM)  sum_seen[s] <= 1'b1;
          if (int'(cfg_term) == N_SUM) en_seen[s]  <= 1'b1;
        end
      end
      if (int'(cfg_term) <= N_SUM) any_seen <= 1'b1;
    end
  end

  // R1: first cycle after reset shows cleared pins
  a_r1_reset_zero: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (pin_out == '0 && pin_oe == '0));

  // R7: writes with an out-of-range index (or none) leave the array quiet
  a_r7_quiet_until_config: assert property (@(posedge clk) disable iff (rst)
    !any_seen |-> (pin_out == '0 && pin_oe == '0));

  for (genvar s = 0; s < N_SEC; s++) begin : g_sec_chk
    // R3: a pin can only go high after a sum term of its own section was loaded
    a_r3_out_needs_sum_term: assert property (@(posedge clk) disable iff (rst)
      !sum_seen[s] |-> !pin_out[s]);
    // R4: enable only after the section's enable term was loaded
    a_r4_oe_needs_enable_term: assert property (@(posedge clk) disable iff (rst)
      !en_seen[s] |-> !pin_oe[s]);
  end

endmodule

bind pal_macro_array pal_macro_array_chk #(
  .N_SEC (N_SEC),
  .N_SUM (N_SUM),
  .SEC_W (SEC_W),
  .TIDX_W(TIDX_W),
  .CODE_W(CODE_W)
) chk_i (
  .clk     (clk),
  .rst     (rst),
  .cfg_we  (cfg_we),
  .cfg_sec (cfg_sec),
  .cfg_term(cfg_term),
  .cfg_data(cfg_data),
  .pin_out (pin_out),
  .pin_oe  (pin_oe)
);

// File: tb/pal_macro_array_tb_top.sv
module pal_macro_array_tb_top;

  localparam logic [15:0] ALL_ANY = 16'hFFFF;
  localparam int IA = 0, IB = 1, IC = 2, ID = 3;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_we = 1'b0;
  logic [1:0] cfg_sec = '0;
  logic [2:0] cfg_term = '0;
  logic [15:0] cfg_data = '0;
  logic [3:0] ded_in = '0;
  logic [3:0] pin_in = '0;
  logic [3:0] pin_out, pin_oe;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  string req_tag = "R1";

  // behavioural reference state
  logic [15:0] mcfg [4][5];
  logic [3:0]  mout, moe;

  always #10 clk = ~clk;

  pal_macro_array dut_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sec(cfg_sec),
    .cfg_term(cfg_term), .cfg_data(cfg_data), .ded_in(ded_in),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  function automatic logic [15:0] lit(input logic [15:0] base, input int idx,
                                      input logic [1:0] c);
    logic [15:0] r = base;
    r[2*idx +: 2] = c;
    return r;
  endfunction

  function automatic bit term_true(input logic [15:0] w, input logic [7:0] s,
                                   input int own);
    bit v = 1;
    for (int j = 0; j < 8; j++) begin
      if (j == own) continue;
      case (w[2*j +: 2])
        2'b00: v = 0;
        2'b01: v = v & s[j];
        2'b10: v = v & ~s[j];
        default: ;
      endcase
    end
    return v;
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int s = 0; s < 4; s++)
      for (int t = 0; t < 5; t++) mcfg[s][t] = '0;
    mout = '0;
    moe  = '0;
  endtask

  // one clock: drive at negedge, advance model at the edge, compare after it
  task automatic tick(input logic [3:0] din, input logic [3:0] pin,
                      input logic we = 0, input logic [1:0] sec = 0,
                      input logic [2:0] term = 0, input logic [15:0] data = 0);
    logic [3:0] nout, noe, fbv;
    logic [7:0] sigs;
    @(negedge clk);
    ded_in = din; pin_in = pin; cfg_we = we; cfg_sec = sec;
    cfg_term = term; cfg_data = data;
    for (int s = 0; s < 4; s++) fbv[s] = moe[s] ? mout[s] : pin[s];
    sigs = {fbv, din};
    for (int s = 0; s < 4; s++) begin
      bit acc = 0;
      for (int t = 0; t < 4; t++) acc = acc | term_true(mcfg[s][t], sigs, 4 + s);
      nout[s] = acc;
      noe[s]  = term_true(mcfg[s][4], sigs, 4 + s);
    end
    @(posedge clk);
    mout = nout;
    moe  = noe;
    if (we && term <= 3'd4) mcfg[sec][term] = data;
    #2;
    chk(req_tag, "pin_out vs model", pin_out, mout);
    chk(req_tag, "pin_oe vs model", pin_oe, moe);
  endtask

  task automatic wr(input logic [1:0] sec, input logic [2:0] term,
                    input logic [15:0] data);
    tick(4'h0, 4'h0, 1'b1, sec, term, data);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; cfg_we = 0; ded_in = '0; pin_in = '0;
    repeat (2) @(posedge clk);
    #2;
    model_clear();
    chk("R1", "pin_out after reset", pin_out, 4'h0);
    chk("R1", "pin_oe after reset", pin_oe, 4'h0);
    @(negedge clk);
    rst = 0;
  endtask

  function automatic bit six_prod(input logic [3:0] v);
    bit a = v[0], b = v[1], c = v[2], d = v[3];
    return (a & b) | (~a & c) | (b & ~d) | (c & d) | (~b & ~c & d) | (a & ~c & ~d);
  endfunction

  initial begin
    model_clear();
    // R1: reset state
    do_reset();
    tick(4'hF, 4'hF);

    // R7: write with index 5 is ignored
    req_tag = "R7";
    wr(2'd0, 3'd5, ALL_ANY);
    wr(2'd2, 3'd7, ALL_ANY);
    tick(4'hF, 4'h0);
    tick(4'h0, 4'hF);
    chk("R7", "pins after bad-index writes", pin_out | pin_oe, 4'h0);

    // R2/R3: sum of A&~B and C&D, plus a term forced to 0 by one code
    do_reset();
    req_tag = "R2";
    wr(2'd0, 3'd0, lit(lit(ALL_ANY, IA, 2'b01), IB, 2'b10));
    wr(2'd0, 3'd1, lit(lit(ALL_ANY, IC, 2'b01), ID, 2'b01));
    wr(2'd0, 3'd2, lit(ALL_ANY, ID, 2'b00));
    wr(2'd0, 3'd4, lit(ALL_ANY, IA, 2'b01));
    for (int v = 0; v < 16; v++) begin
      logic [3:0] x = 4'(v);
      tick(x, 4'h0);
      chk("R3", "sec0 sum", {3'b0, pin_out[0]}, {3'b0, (x[0] & ~x[1]) | (x[2] & x[3])});
      chk("R4", "sec0 enable follows A", {3'b0, pin_oe[0]}, {3'b0, x[0]});
    end

    // R5: feedback source depends on enable
    do_reset();
    req_tag = "R5";
    wr(2'd1, 3'd0, lit(ALL_ANY, IA, 2'b01));
    wr(2'd1, 3'd4, ALL_ANY);
    wr(2'd2, 3'd0, lit(ALL_ANY, 5, 2'b01));
    wr(2'd2, 3'd4, ALL_ANY);
    for (int v = 0; v < 4; v++) begin
      logic a = v[0];
      tick({3'b0, a}, {2'b0, ~a, 1'b0});
      tick({3'b0, a}, {2'b0, ~a, 1'b0});
      chk("R5", "driven feedback", {3'b0, pin_out[2]}, {3'b0, a});
      chk("R4", "constant enable", {3'b0, pin_oe[1]}, 4'h1);
    end
    wr(2'd1, 3'd4, 16'h0000);
    for (int v = 0; v < 4; v++) begin
      logic p = v[0];
      tick(4'h1, {2'b0, p, 1'b0});
      tick(4'h1, {2'b0, p, 1'b0});
      chk("R5", "undriven feedback uses pin_in", {3'b0, pin_out[2]}, {3'b0, p});
      chk("R4", "enable cleared", {3'b0, pin_oe[1]}, 4'h0);
    end

    // R6/R8: own feedback code ignored; other sections untouched
    do_reset();
    req_tag = "R6";
    wr(2'd0, 3'd0, lit(ALL_ANY, IB, 2'b01));
    wr(2'd3, 3'd0, lit(ALL_ANY, 7, 2'b00));
    wr(2'd3, 3'd4, lit(ALL_ANY, 7, 2'b10));
    tick(4'h2, 4'h0);
    tick(4'h2, 4'h0);
    chk("R6", "own force-0 ignored", {3'b0, pin_out[3]}, 4'h1);
    chk("R6", "own complement ignored", {3'b0, pin_oe[3]}, 4'h1);
    chk("R8", "sec0 unaffected by sec3 writes", {3'b0, pin_out[0]}, 4'h1);
    req_tag = "R8";
    wr(2'd3, 3'd1, ALL_ANY);
    tick(4'h2, 4'h0);
    chk("R8", "sec0 after another sec3 write", {3'b0, pin_out[0]}, 4'h1);
    chk("R8", "sections 1,2 idle", {2'b0, pin_out[2:1]}, 4'h0);

    // R9: six products through a helper section
    do_reset();
    req_tag = "R9";
    wr(2'd1, 3'd0, lit(lit(ALL_ANY, IA, 2'b01), IB, 2'b01));
    wr(2'd1, 3'd1, lit(lit(ALL_ANY, IA, 2'b10), IC, 2'b01));
    wr(2'd1, 3'd2, lit(lit(ALL_ANY, IB, 2'b01), ID, 2'b10));
    wr(2'd1, 3'd3, lit(lit(ALL_ANY, IC, 2'b01), ID, 2'b01));
    wr(2'd1, 3'd4, ALL_ANY);
    wr(2'd2, 3'd0, lit(ALL_ANY, 5, 2'b01));
    wr(2'd2, 3'd1, lit(lit(lit(ALL_ANY, IB, 2'b10), IC, 2'b10), ID, 2'b01));
    wr(2'd2, 3'd2, lit(lit(lit(ALL_ANY, IA, 2'b01), IC, 2'b10), ID, 2'b10));
    wr(2'd2, 3'd4, ALL_ANY);
    for (int v = 0; v < 16; v++) begin
      logic [3:0] x = 4'(v);
      tick(x, 4'h0);
      tick(x, 4'h0);
      chk("R9", "six-product result", {3'b0, pin_out[2]}, {3'b0, six_prod(x)});
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule